// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches a vector of already-synchronized general purpose input levels and turns them into interrupt requests. Each pin is given its own trigger choice through three configuration vectors: a sense vector that picks level or edge behaviour, a both-edges vector, and an event vector that picks polarity or edge direction. An enable vector gates each pin onto the interrupt output, and a one-cycle clear vector removes captured edge events.

Edge events are captured in a per-pin flag that stays set until software clears it by writing a one for that pin. Level events are never stored: their status follows the pin, and a clear has no effect on them. Every pin's status is shown raw and, after the enable gate, masked. A single interrupt line is high whenever any masked bit is high. Address decoding, input synchronization and priority encoding sit outside this block.

Top module: `gpio_irq_detect`

## Requirements
- R1: While reset is high and in the first cycle after it, the edge flags are 0, and a pin level held steady through reset release records no edge.
- R2: A pin with sense 1 and event 1 shows raw status equal to its current input level, with no register delay.
- R3: A pin with sense 1 and event 0 shows raw status equal to the inverse of its current input level.
- R4: A pin with sense 0, both-edges 0 and event 1 sets its edge flag on the clock edge where its input is 1 and was 0 at the previous clock edge; raw status shows it from the following cycle.
- R5: A pin with sense 0, both-edges 0 and event 0 sets its edge flag when its input goes from 1 to 0 between clock edges.
- R6: A pin with sense 0 and both-edges 1 sets its edge flag on any change of its input, whatever the event bit holds.
- R7: An edge flag stays set until a clock edge with that pin's clear bit at 1; clear bits at 0 leave flags unchanged.
- R8: The clear vector has no effect on the raw status of a level-sensitive pin; it falls only when the input leaves the active level.
- R9: An edge detected on the same clock edge as a clear for that pin leaves the flag set.
- R10: Masked status equals raw status ANDed with the enable vector, and raw status records events for pins whose enable bit is 0.
- R11: The interrupt output is 1 exactly when at least one masked status bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_level | input | NPINS | Synchronized input levels |
| sense_level | input | NPINS | 1: level-sensitive, 0: edge-sensitive |
| both_edges | input | NPINS | 1: edge pins trigger on either direction |
| event_pol | input | NPINS | Level: 1 high / 0 low; edge: 1 rising / 0 falling |
| irq_enable | input | NPINS | Per-pin gate onto masked status |
| clear_w1c | input | NPINS | One-cycle pulse, 1 clears that pin's edge flag |
| raw_status | output | NPINS | Per-pin event status before enable |
| masked_status | output | NPINS | Raw status ANDed with enable |
| irq_out | output | 1 | OR of all masked status bits |

## Verification
Directed sequences drive each trigger mode in turn, so that a rising-only pin is shown to ignore a falling transition, a falling-only pin to ignore a rising one, and a both-edges pin to react to either transition with the event bit set against it. Clears are applied to latched edges, to asserted level pins and in the same cycle as a fresh edge, which separates a correct write-one-to-clear from one that wipes level status or loses the racing edge. A long run of random pins, configurations, enables and sparse clear pulses then compares every output each cycle against a bench model, catching mode mixing and stale flags after a pin changes mode.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Trigger choice decoded from the three configuration bits of a pin.
    typedef enum logic [2:0] {
        TRIG_LVL_LOW   = 3'd0,
        TRIG_LVL_HIGH  = 3'd1,
        TRIG_EDGE_FALL = 3'd2,
        TRIG_EDGE_RISE = 3'd3,
        TRIG_EDGE_BOTH = 3'd4
    } trig_mode_e;

    typedef struct packed {
        logic sense;   // 1: level, 0: edge
        logic both;    // 1: any transition (edge mode only)
        logic pol;     // polarity / direction
    } pin_cfg_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_pair_t;

    function automatic trig_mode_e decode_mode(pin_cfg_t c);
        trig_mode_e m;
        if (c.sense)
            m = c.pol ? TRIG_LVL_HIGH : TRIG_LVL_LOW;
        else if (c.both)
            m = TRIG_EDGE_BOTH;       // polarity bit not consulted
        else
            m = c.pol ? TRIG_EDGE_RISE : TRIG_EDGE_FALL;
        return m;
    endfunction

    function automatic logic is_level_mode(trig_mode_e m);
        return (m == TRIG_LVL_LOW) || (m == TRIG_LVL_HIGH);
    endfunction

    function automatic logic edge_hit(trig_mode_e m, edge_pair_t e);
        logic h;
        case (m)
            TRIG_EDGE_RISE: h = e.rise;
            TRIG_EDGE_FALL: h = e.fall;
            TRIG_EDGE_BOTH: h = e.rise | e.fall;
            default:        h = 1'b0;
        endcase
        return h;
    endfunction

    function automatic logic level_hit(trig_mode_e m, logic lvl);
        logic h;
        case (m)
            TRIG_LVL_HIGH: h = lvl;
            TRIG_LVL_LOW:  h = ~lvl;
            default:       h = 1'b0;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/gpio_irq_sampler.sv
module gpio_irq_sampler
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic       [NPINS-1:0] pin_i,
    output edge_pair_t [NPINS-1:0] edges_o
);

    logic [NPINS-1:0] prev_q;

    // The previous sample follows the input during reset as well, so
    // the first cycle after release compares like with like.
    always_ff @(posedge clk) begin
        if (rst) prev_q <= pin_i;
        else     prev_q <= pin_i;
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_edge
        always_comb begin
            edges_o[i].rise = pin_i[i] & ~prev_q[i];
            edges_o[i].fall = ~pin_i[i] & prev_q[i];
        end
    end

endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
    import gpio_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pin_cfg_t   cfg_i,
    input  logic       level_i,
    input  edge_pair_t edge_i,
    input  logic       clear_i,
    output logic       raw_o
);

    trig_mode_e mode;
    logic       set_flag;
    logic       flag_q;

    always_comb begin
        mode     = decode_mode(cfg_i);
        set_flag = edge_hit(mode, edge_i);
    end

    // A new edge takes precedence over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= set_flag | (flag_q & ~clear_i);
    end

    always_comb begin
        if (is_level_mode(mode)) raw_o = level_hit(mode, level_i);
        else                     raw_o = flag_q;
    end

endmodule

// File: rtl/gpio_irq_combine.sv
module gpio_irq_combine #(
    parameter int NPINS = 8
) (
    input  logic [NPINS-1:0] raw_i,
    input  logic [NPINS-1:0] enable_i,
    output logic [NPINS-1:0] masked_o,
    output logic             irq_o
);

    always_comb begin
        masked_o = raw_i & enable_i;
        irq_o    = |masked_o;
    end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pin_level,
    input  logic [NPINS-1:0] sense_level,
    input  logic [NPINS-1:0] both_edges,
    input  logic [NPINS-1:0] event_pol,
    input  logic [NPINS-1:0] irq_enable,
    input  logic [NPINS-1:0] clear_w1c,
    output logic [NPINS-1:0] raw_status,
    output logic [NPINS-1:0] masked_status,
    output logic             irq_out
);

    edge_pair_t [NPINS-1:0] edges;

    gpio_irq_sampler #(.NPINS(NPINS)) u_sampler (
        .clk     (clk),
        .rst     (rst),
        .pin_i   (pin_level),
        .edges_o (edges)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pin_cfg_t cfg;
        always_comb begin
            cfg.sense = sense_level[i];
            cfg.both  = both_edges[i];
            cfg.pol   = event_pol[i];
        end

        gpio_irq_pin u_pin (
            .clk     (clk),
            .rst     (rst),
            .cfg_i   (cfg),
            .level_i (pin_level[i]),
            .edge_i  (edges[i]),
            .clear_i (clear_w1c[i]),
            .raw_o   (raw_status[i])
        );
    end

    gpio_irq_combine #(.NPINS(NPINS)) u_combine (
        .raw_i    (raw_status),
        .enable_i (irq_enable),
        .masked_o (masked_status),
        .irq_o    (irq_out)
    );

endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
    parameter int NPINS = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [NPINS-1:0] pin_level,
    input logic [NPINS-1:0] sense_level,
    input logic [NPINS-1:0] both_edges,
    input logic [NPINS-1:0] event_pol,
    input logic [NPINS-1:0] irq_enable,
    input logic [NPINS-1:0] clear_w1c,
    input logic [NPINS-1:0] raw_status,
    input logic [NPINS-1:0] masked_status,
    input logic             irq_out
);

    logic [NPINS-1:0] pin_d;
    logic [NPINS-1:0] hit;

    always_ff @(posedge clk) pin_d <= pin_level;

    always_comb begin
        for (int i = 0; i < NPINS; i++) begin
            if (sense_level[i])     hit[i] = 1'b0;
            else if (both_edges[i]) hit[i] = pin_level[i] ^ pin_d[i];
            else if (event_pol[i])  hit[i] = pin_level[i] & ~pin_d[i];
            else                    hit[i] = ~pin_level[i] & pin_d[i];
        end
    end

    // R4 R5 R6 R9: a detected edge is visible next cycle, clear or not
    assert_edge_capture_R9: assert property (@(posedge clk) disable iff (rst)
        (hit != '0) |=> (((raw_status | sense_level) & $past(hit)) == $past(hit)));

    // R7: an edge flag without a clear is still set next cycle
    assert_flag_hold_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(raw_status) & ~$past(clear_w1c) & ~$past(sense_level)
                    & ~sense_level) & ~raw_status) == '0));

    // R8: an active level pin reports status whatever the clear vector holds
    assert_level_active_R8: assert property (@(posedge clk) disable iff (rst)
        ((sense_level & ~(pin_level ^ event_pol) & ~raw_status) == '0));

    // R10: masked status never shows a disabled or inactive pin
    assert_mask_gate_R10: assert property (@(posedge clk) disable iff (rst)
        ((masked_status & ~(raw_status & irq_enable)) == '0));

    // R11: interrupt line tracks the presence of any masked bit
    assert_irq_line_R11: assert property (@(posedge clk) disable iff (rst)
        irq_out == (masked_status != '0));

endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NPINS(NPINS)) u_chk (.*);

// File: tb/gpio_irq_detect_tb.sv
module gpio_irq_detect_tb;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] pin_level = '0, sense_level = '0, both_edges = '0;
    logic [N-1:0] event_pol = '0, irq_enable = '0, clear_w1c = '0;
    logic [N-1:0] raw_status, masked_status;
    logic         irq_out;

    int checks = 0;
    int errors = 0;

    logic [N-1:0] m_prev = '0;
    logic [N-1:0] m_flag = '0;

    always #2 clk = ~clk;

    gpio_irq_detect #(.NPINS(N)) u_dut (.*);

    function automatic logic [N-1:0] exp_raw();
        logic [N-1:0] r;
        for (int i = 0; i < N; i++)
            r[i] = sense_level[i] ? ~(pin_level[i] ^ event_pol[i]) : m_flag[i];
        return r;
    endfunction

    function automatic logic [N-1:0] edge_set();
        logic [N-1:0] h;
        for (int i = 0; i < N; i++) begin
            if (sense_level[i])     h[i] = 1'b0;
            else if (both_edges[i]) h[i] = pin_level[i] ^ m_prev[i];
            else if (event_pol[i])  h[i] = pin_level[i] & ~m_prev[i];
            else                    h[i] = ~pin_level[i] & m_prev[i];
        end
        return h;
    endfunction

    task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        logic [N-1:0] er;
        er = exp_raw();
        check(tag, raw_status, er);
        check("R10", masked_status, er & irq_enable);
        check("R11", {{(N-1){1'b0}}, irq_out}, {{(N-1){1'b0}}, |(er & irq_enable)});
    endtask

    // Drive at negedge, model the clock edge, sample 1 ns later.
    task automatic step(string tag, logic [N-1:0] p, logic [N-1:0] s,
                        logic [N-1:0] b, logic [N-1:0] e,
                        logic [N-1:0] en, logic [N-1:0] c);
        @(negedge clk);
        pin_level = p; sense_level = s; both_edges = b;
        event_pol = e; irq_enable = en; clear_w1c = c;
        @(posedge clk);
        if (rst) begin
            m_flag = '0;
        end else begin
            m_flag = edge_set() | (m_flag & ~clear_w1c);
        end
        m_prev = pin_level;
        #1;
        check_all(tag);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [N-1:0] p, s, b, e, en, c;
        process_seed();
        // R1: reset with a nonzero pin pattern in rising-edge mode
        rst = 1'b1;
        for (int k = 0; k < 3; k++) step("R1", 8'hA5, '0, '0, '1, '1, '0);
        @(negedge clk); rst = 1'b0;
        step("R1", 8'hA5, '0, '0, '1, '1, '0);
        step("R1", 8'hA5, '0, '0, '1, '1, '0);
        check("R1", raw_status, 8'h00);

        // R2: level high follows pin, R3: level low inverts
        step("R2", 8'h3C, '1, '0, '1, '1, '0);
        check("R2", raw_status, 8'h3C);
        step("R3", 8'h3C, '1, '0, '0, '1, '0);
        check("R3", raw_status, 8'hC3);
        // R8: clear on active level pins leaves status
        step("R8", 8'h3C, '1, '0, '1, '1, '1);
        check("R8", raw_status, 8'h3C);
        step("R8", 8'h00, '1, '0, '1, '1, '0);
        check("R8", raw_status, 8'h00);

        // R4: rising edges, falling ignored
        step("R4", 8'h00, '0, '0, '1, '1, '1);
        step("R4", 8'h0F, '0, '0, '1, '1, '0);
        check("R4", raw_status, 8'h0F);
        step("R4", 8'h00, '0, '0, '1, '1, '0);
        check("R7", raw_status, 8'h0F);
        step("R7", 8'h00, '0, '0, '1, '1, 8'h03);
        check("R7", raw_status, 8'h0C);
        step("R7", 8'h00, '0, '0, '1, '1, 8'h00);
        check("R7", raw_status, 8'h0C);

        // R5: falling edges, rising ignored
        step("R5", 8'h00, '0, '0, '0, '1, '1);
        step("R5", 8'hFF, '0, '0, '0, '1, '0);
        check("R5", raw_status, 8'h00);
        step("R5", 8'h00, '0, '0, '0, '1, '0);
        check("R5", raw_status, 8'hFF);

        // R6: both edges, event bit mixed and ignored
        step("R6", 8'h00, '0, '1, 8'h55, '1, '1);
        step("R6", 8'hF0, '0, '1, 8'h55, '1, '0);
        check("R6", raw_status, 8'hF0);
        step("R6", 8'hF0, '0, '1, 8'h55, '1, '1);
        step("R6", 8'h00, '0, '1, 8'h55, '1, '0);
        check("R6", raw_status, 8'hF0);

        // R9: edge in the same cycle as a clear stays set
        step("R9", 8'h00, '0, '0, '1, '1, '1);
        step("R9", 8'h81, '0, '0, '1, '1, 8'hFF);
        check("R9", raw_status, 8'h81);

        // R10: disabled pins still record raw events
        step("R10", 8'h00, '0, '0, '1, 8'h0F, '1);
        step("R10", 8'hF0, '0, '0, '1, 8'h0F, '0);
        check("R10", raw_status, 8'hF0);
        check("R10", masked_status, 8'h00);
        check("R11", {7'd0, irq_out}, 8'h00);

        // Random mix against the bench model
        s = '0; b = '0; e = '1; en = '1;
        for (int k = 0; k < 4000; k++) begin
            p = pin_level;
            for (int i = 0; i < N; i++)
                if ($urandom_range(3) == 0) p[i] = ~p[i];
            if ($urandom_range(15) == 0) begin
                s = N'($urandom); b = N'($urandom);
                e = N'($urandom); en = N'($urandom);
            end
            c = N'($urandom) & N'($urandom) & N'($urandom);
            step("R7", p, s, b, e, en, c);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic process_seed();
        int unsigned dummy;
        dummy = $urandom(32'd1729);
    endtask

endmodule